// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block governs the power-down state of a small processor core. When instruction decode signals a sleep request, the controller decides in that same cycle whether to really power down. If an enabled interrupt is already pending, the request is treated as a no-op. Otherwise it pulses a watchdog clear, updates the power-down and time-out status flags, and turns off the registered core-clock enable. The block runs from an always-on clock and stays live while the core clock is gated.

While asleep, three events can end the sleep, checked in this order: the external reset input, a watchdog time-out, and any interrupt source whose flag and individual enable are both set.

- An external reset only returns the core to the running state. The full device reset is handled elsewhere, and the status flags are kept so that software can tell what happened.
- A watchdog wake clears the time-out flag.
- An interrupt wake ignores the global interrupt enable. That enable only decides whether, one cycle after the clock comes back (once the prefetched instruction has run), a one-cycle request to branch to the interrupt vector is raised.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While power-on reset `por_n` is low, and after it is released, `pd_flag`=1, `to_flag`=1, `core_clk_en`=1, `wdt_clr`=0 and `vec_req`=0.
- R2: A `sleep_req` seen while running, with no source having both `irq_flag[i]` and `irq_en[i]` set, gives on the next cycle `core_clk_en`=0, `pd_flag`=0, `to_flag`=1, and `wdt_clr`=1 for exactly one cycle.
- R3: A `sleep_req` seen while some source has both flag and enable set is a no-op: `core_clk_en` stays 1, `wdt_clr` stays 0, and `pd_flag` and `to_flag` keep their values.
- R4: While asleep, a source with flag and enable both set gives `core_clk_en`=1 on the next cycle, whatever `gie` is, and leaves `pd_flag`=0 and `to_flag`=1.
- R5: A flag whose enable is clear, or an enable whose flag is clear, neither blocks sleep entry nor wakes the core.
- R6: After an interrupt wake, `vec_req` is 1 for exactly one cycle. This is the second cycle after the wake edge, and only if `gie` was 1 in the wake cycle. In all other cases `vec_req` stays 0.
- R7: A `wdt_timeout` seen while asleep wakes the core on the next cycle with `to_flag`=0 and `pd_flag`=0, and no `vec_req`.
- R8: A `wdt_timeout` seen while running changes neither `pd_flag` nor `to_flag`, and does not gate the clock.
- R9: `ext_rst` returns the core to running on the next cycle (`core_clk_en`=1, `vec_req`=0) and keeps `pd_flag` and `to_flag` unchanged.
- R10: Wake events arriving together are resolved as external reset over watchdog over interrupt. `ext_rst` with `wdt_timeout` leaves `to_flag`=1. `wdt_timeout` with an enabled interrupt clears `to_flag` and raises no `vec_req`.
- R11: A `sleep_req` seen while asleep is ignored: no `wdt_clr` and the core stays asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset request, synchronous, active high |
| sleep_req | input | 1 | One-cycle sleep request from instruction decode |
| irq_flag | input | N_SRC | Pending interrupt flags, synchronous |
| irq_en | input | N_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| core_clk_en | output | 1 | Registered core clock enable |
| wdt_clr | output | 1 | One-cycle watchdog and postscaler clear |
| vec_req | output | 1 | One-cycle branch-to-interrupt-vector request |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to the controller clock.
- Decode raises `sleep_req` only while the core clock runs, since a gated core cannot decode.
- `wdt_timeout` is a strobe of at most a few cycles.

The directed stimulus keeps to these assumptions. It drives every input half a cycle away from the active edge. It asserts `sleep_req` while asleep only in the scenario that checks that such a request is ignored. It raises simultaneous wake events only in the precedence scenario.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst,
  input  logic             sleep_req,
  input  logic [N_SRC-1:0] irq_flag,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             gie,
  input  logic             wdt_timeout,
  output logic             core_clk_en,
  output logic             wdt_clr,
  output logic             vec_req,
  output logic             pd_flag,
  output logic             to_flag
);

  logic asleep, resume, resume_gie;
  logic pend, go_sleep, wake_wdt, wake_irq;

  assign pend     = |(irq_flag & irq_en);
  assign go_sleep = !ext_rst && !asleep && !resume && sleep_req && !pend;
  assign wake_wdt = asleep && !ext_rst && wdt_timeout;
  assign wake_irq = asleep && !ext_rst && !wdt_timeout && pend;
  assign core_clk_en = !asleep;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      asleep     <= 1'b0;
      resume     <= 1'b0;
      resume_gie <= 1'b0;
      vec_req    <= 1'b0;
      wdt_clr    <= 1'b0;
      pd_flag    <= 1'b1;
      to_flag    <= 1'b1;
    end else begin
      wdt_clr    <= go_sleep;
      resume     <= wake_irq;
      resume_gie <= wake_irq && gie;
      vec_req    <= !ext_rst && resume && resume_gie;
      if (ext_rst || wake_wdt || wake_irq) asleep <= 1'b0;
      else if (go_sleep)                   asleep <= 1'b1;
      if (go_sleep) begin
        pd_flag <= 1'b0;
        to_flag <= 1'b1;
      end else if (wake_wdt) begin
        to_flag <= 1'b0;
      end
    end
  end

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!asleep && !resume && sleep_req && !pend && !ext_rst)
      |=> (!core_clk_en && wdt_clr && !pd_flag && to_flag));

  assert_wdt_clr_pulse_R2: assert property (@(posedge clk) disable iff (!por_n)
    wdt_clr |=> !wdt_clr);

  assert_noop_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!asleep && sleep_req && pend)
      |=> (core_clk_en && !wdt_clr && $stable(pd_flag) && $stable(to_flag)));

  assert_irq_wake_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!core_clk_en && pend) |=> core_clk_en);

  assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (!por_n)
    vec_req |=> !vec_req);

  assert_vec_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
    vec_req |-> ($past(gie, 2) && $past(core_clk_en) && !$past(core_clk_en, 2)));

  assert_to_fall_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(to_flag) |-> ($past(wdt_timeout) && !$past(core_clk_en)));

  assert_wdt_run_R8: assert property (@(posedge clk) disable iff (!por_n)
    (core_clk_en && wdt_timeout && !sleep_req) |=> ($stable(pd_flag) && $stable(to_flag)));

  assert_ext_rst_R9: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst |=> (core_clk_en && !vec_req && $stable(pd_flag) && $stable(to_flag)));

  assert_pd_fall_R2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pd_flag) |-> $past(sleep_req));

endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  localparam int N = 8;
  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst = 1'b0, sleep_req = 1'b0, gie = 1'b0, wdt_timeout = 1'b0;
  logic [N-1:0] irq_flag = '0, irq_en = '0;
  logic core_clk_en, wdt_clr, vec_req, pd_flag, to_flag;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.N_SRC(N)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .sleep_req(sleep_req),
    .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout),
    .core_clk_en(core_clk_en), .wdt_clr(wdt_clr), .vec_req(vec_req),
    .pd_flag(pd_flag), .to_flag(to_flag));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter_sleep(input string req);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk(req, "clk_en after sleep", core_clk_en, 1'b0);
    chk(req, "wdt_clr pulse", wdt_clr, 1'b1);
    chk(req, "pd after sleep", pd_flag, 1'b0);
    chk(req, "to after sleep", to_flag, 1'b1);
    tick();
    chk(req, "wdt_clr single cycle", wdt_clr, 1'b0);
    chk(req, "still asleep", core_clk_en, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "clk_en in reset", core_clk_en, 1'b1);
    chk("R1", "pd in reset", pd_flag, 1'b1);
    tick(); por_n = 1'b1; tick();
    chk("R1", "pd after reset", pd_flag, 1'b1);
    chk("R1", "to after reset", to_flag, 1'b1);
    chk("R1", "clk_en after reset", core_clk_en, 1'b1);
    chk("R1", "wdt_clr after reset", wdt_clr, 1'b0);
    chk("R1", "vec after reset", vec_req, 1'b0);
  endtask

  task automatic t_noop(input logic exp_to);
    irq_flag = 8'h10; irq_en = 8'h10; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R3", "no-op clk_en", core_clk_en, 1'b1);
    chk("R3", "no-op wdt_clr", wdt_clr, 1'b0);
    chk("R3", "no-op to", to_flag, exp_to);
    irq_flag = '0; irq_en = '0;
    tick();
    chk("R3", "no-op vec", vec_req, 1'b0);
  endtask

  task automatic t_irq_wake(input logic g);
    enter_sleep("R2");
    tick();
    gie = g; irq_flag = 8'h04; irq_en = 8'h04;
    tick();
    irq_flag = '0; gie = 1'b0;
    chk("R4", "irq wake clk_en", core_clk_en, 1'b1);
    chk("R4", "pd after irq wake", pd_flag, 1'b0);
    chk("R4", "to after irq wake", to_flag, 1'b1);
    chk("R6", "vec in resume cycle", vec_req, 1'b0);
    tick();
    chk("R6", "vec second cycle", vec_req, g);
    tick();
    chk("R6", "vec ends", vec_req, 1'b0);
    irq_en = '0;
  endtask

  task automatic t_disabled_src();
    irq_flag = 8'h02; irq_en = 8'h08;
    enter_sleep("R5");
    tick(); tick();
    chk("R5", "non-enabled flag no wake", core_clk_en, 1'b0);
    irq_flag = 8'h08;
    tick();
    chk("R5", "matching pair wakes", core_clk_en, 1'b1);
    irq_flag = '0; irq_en = '0;
    tick(); tick();
  endtask

  task automatic t_wdt_wake();
    enter_sleep("R2");
    gie = 1'b1; wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R7", "wdt wake clk_en", core_clk_en, 1'b1);
    chk("R7", "wdt wake to", to_flag, 1'b0);
    chk("R7", "wdt wake pd", pd_flag, 1'b0);
    tick();
    chk("R7", "wdt wake no vec", vec_req, 1'b0);
    tick();
    chk("R7", "wdt wake no vec later", vec_req, 1'b0);
    gie = 1'b0;
  endtask

  task automatic t_wdt_run();
    wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R8", "wdt running to", to_flag, 1'b1);
    chk("R8", "wdt running pd", pd_flag, 1'b0);
    chk("R8", "wdt running clk_en", core_clk_en, 1'b1);
  endtask

  task automatic t_ext_rst();
    enter_sleep("R2");
    ext_rst = 1'b1;
    tick();
    ext_rst = 1'b0;
    chk("R9", "ext rst clk_en", core_clk_en, 1'b1);
    chk("R9", "ext rst pd", pd_flag, 1'b0);
    chk("R9", "ext rst to", to_flag, 1'b1);
    chk("R9", "ext rst vec", vec_req, 1'b0);
  endtask

  task automatic t_precedence();
    enter_sleep("R2");
    ext_rst = 1'b1; wdt_timeout = 1'b1;
    tick();
    ext_rst = 1'b0; wdt_timeout = 1'b0;
    chk("R10", "rst over wdt awake", core_clk_en, 1'b1);
    chk("R10", "rst over wdt to kept", to_flag, 1'b1);
    tick();
    enter_sleep("R2");
    gie = 1'b1; wdt_timeout = 1'b1; irq_flag = 8'h01; irq_en = 8'h01;
    tick();
    wdt_timeout = 1'b0; irq_flag = '0; irq_en = '0; gie = 1'b0;
    chk("R10", "wdt over irq to", to_flag, 1'b0);
    chk("R10", "wdt over irq awake", core_clk_en, 1'b1);
    tick();
    chk("R10", "wdt over irq no vec", vec_req, 1'b0);
    tick();
    chk("R10", "wdt over irq no vec later", vec_req, 1'b0);
  endtask

  task automatic t_sleep_while_asleep();
    enter_sleep("R2");
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R11", "no wdt_clr while asleep", wdt_clr, 1'b0);
    chk("R11", "stays asleep", core_clk_en, 1'b0);
    ext_rst = 1'b1;
    tick();
    ext_rst = 1'b0;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_noop(1'b1);
    chk("R3", "no-op keeps pd set", pd_flag, 1'b1);
    t_irq_wake(1'b0);
    t_irq_wake(1'b1);
    t_disabled_src();
    t_wdt_wake();
    t_noop(1'b0);
    chk("R3", "no-op keeps pd clear", pd_flag, 1'b0);
    enter_sleep("R2");
    ext_rst = 1'b1; tick(); ext_rst = 1'b0; tick();
    t_wdt_run();
    t_ext_rst();
    t_precedence();
    t_sleep_while_asleep();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule